// File: doc/BRIEF.md
# Flexible Pulse-Per-Second Generator

This block drives a periodic pulse train whose first rising edge is tied to an absolute point on a free-running system time made of a seconds count and a sub-second count. Software programs a target start time, an interval and a width through a simple write port. It then issues a start command. Once the system time reaches the target, the output goes high and the train repeats. The interval and the width are both counted in sub-second increment ticks supplied by the time base.

A busy flag marks a target sub-second value that has been written but not yet reached. While the flag is set, new timing programming is refused. The time base may count sub-seconds either in decimal (nanoseconds) or in binary rollover (about 0.465 ns per unit). In decimal mode the block refuses a target sub-second value that could never be reached. A stop command lets the pulse in progress finish and then holds the output low.

Top module: `fpps_gen`

## Requirements
- R1: After a synchronous active-low reset, `pps_o` and `trgt_busy_o` are 0, all timing registers are 0 and the train is idle.
- R2: Writes are decoded by address and take effect on the next clock. The addresses are: 0 = control (command in bits [3:0], target mode in bits [9:8]), 1 = target seconds, 2 = target sub-seconds, 3 = interval, 4 = width. Interval and width hold the tick count minus one.
- R3: An accepted write to address 2 sets `trgt_busy_o` on the next cycle. The flag clears on the cycle after a clock edge at which the system time is at or past the target (seconds compared first, then sub-seconds).
- R4: While `trgt_busy_o` is 1, writes to addresses 1, 2, 3 and 4 are ignored.
- R5: A write of 0 to the interval or width register is ignored, because it would mean one increment or less. Interval and width writes are also ignored while the train is armed or running.
- R6: With `dec_rollover_i`=1, a target sub-second write above 999,999,999 is ignored. With `dec_rollover_i`=0 (binary rollover), the same value is accepted.
- R7: A control write with command 0x2 and target mode 0x2 arms the train only if the train is idle and width < interval. Otherwise the start is ignored. This includes any other target mode.
- R8: When the train is armed and the system time is at or past the target at a clock edge, `pps_o` is 1 from the next cycle.
- R9: `pps_o` stays high for width+1 ticks and the train repeats every interval+1 ticks. Between ticks, the output does not change.
- R10: Command 0x5 behaves as follows:
  - While the pulse is high, the pulse completes and the output then stays low.
  - While the pulse is in its low phase, the train goes idle on the next cycle.
  - While the train is armed, it disarms with no pulse.
- R11: Control writes with a command other than 0x2 or 0x5 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_sec_i | input | SEC_W | System time, seconds |
| sys_sub_i | input | SUB_W | System time, sub-seconds |
| inc_tick_i | input | 1 | One-cycle pulse per sub-second increment |
| dec_rollover_i | input | 1 | 1 = sub-seconds roll over in decimal, 0 = binary |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Register write data |
| pps_o | output | 1 | Pulse train output |
| trgt_busy_o | output | 1 | Target pending flag |

## Verification
A phase counter or run state that goes wrong shows on `pps_o` within one tick: an edge arrives early or late, a pulse has the wrong length, or a stopped train keeps pulsing. A busy flag that is set or cleared wrongly shows on `trgt_busy_o` in the very next cycle. It also shows later as refused or accepted programming, which changes the pulse train. A register write that is wrongly accepted or refused is exposed through the pulse timing or through the moment the busy flag clears. The bench therefore compares both outputs against a behavioural model on every clock.

// File: rtl/fpps_pkg.sv
// Shared constants and types for the pulse-per-second generator.
// Assumes the register address field is at least 3 bits wide.
package fpps_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} run_state_e;

    localparam logic [3:0] CMD_START       = 4'h2;
    localparam logic [3:0] CMD_STOP        = 4'h5;
    localparam logic [1:0] MODE_PULSE_ONLY = 2'h2;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_TSEC = 3'd1;
    localparam logic [2:0] A_TSUB = 3'd2;
    localparam logic [2:0] A_INTV = 3'd3;
    localparam logic [2:0] A_WID  = 3'd4;
endpackage

// File: rtl/fpps_cmp.sv
// Target-time comparator: flags when the system time is at or past the target.
// Assumes both times use the same sub-second unit (decimal or binary rollover).
module fpps_cmp #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic [SEC_W-1:0] sec_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic [SEC_W-1:0] tsec_i,
    input  logic [SUB_W-1:0] tsub_i,
    output logic             reached_o
);
    // Seconds decide first; sub-seconds only break a tie on seconds.
    always_comb begin
        if (sec_i != tsec_i) reached_o = (sec_i > tsec_i);
        else                 reached_o = (sub_i >= tsub_i);
    end
endmodule

// File: rtl/fpps_regs.sv
// Register file: target time, interval, width, the busy flag and command decode.
// Assumes DATA_W covers SEC_W, SUB_W, CNT_W and the 10-bit control field.
module fpps_regs
    import fpps_pkg::*;
#(
    parameter int SEC_W       = 32,
    parameter int SUB_W       = 31,
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int SUB_DEC_MAX = 999_999_999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              dec_i,
    input  logic              train_idle_i,
    input  logic              reached_i,
    output logic [SEC_W-1:0]  tsec_o,
    output logic [SUB_W-1:0]  tsub_o,
    output logic [CNT_W-1:0]  intv_o,
    output logic [CNT_W-1:0]  wid_o,
    output logic              busy_o,
    output logic              start_req_o,
    output logic              stop_req_o
);
    localparam logic [SUB_W-1:0] SUB_LIMIT = SUB_W'(SUB_DEC_MAX);

    logic [SEC_W-1:0] tsec_q;
    logic [SUB_W-1:0] tsub_q;
    logic [CNT_W-1:0] intv_q, wid_q;
    logic             busy_q;
    logic             sel_ctrl, sel_tsec, sel_tsub, sel_intv, sel_wid;
    logic             tsub_ok, cnt_ok;
    logic [3:0]       cmd_f;
    logic [1:0]       mode_f;

    // Address decode and write qualification.
    always_comb begin
        sel_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
        sel_tsec = wr_en_i && (wr_addr_i == ADDR_W'(A_TSEC));
        sel_tsub = wr_en_i && (wr_addr_i == ADDR_W'(A_TSUB));
        sel_intv = wr_en_i && (wr_addr_i == ADDR_W'(A_INTV));
        sel_wid  = wr_en_i && (wr_addr_i == ADDR_W'(A_WID));
        tsub_ok  = !(dec_i && (wr_data_i[SUB_W-1:0] > SUB_LIMIT));
        cnt_ok   = !busy_o && train_idle_i && (wr_data_i[CNT_W-1:0] != '0);
        cmd_f    = wr_data_i[3:0];
        mode_f   = wr_data_i[9:8];
    end

    // Command strobes for the train controller.
    always_comb begin
        start_req_o = sel_ctrl && (cmd_f == CMD_START) && (mode_f == MODE_PULSE_ONLY);
        stop_req_o  = sel_ctrl && (cmd_f == CMD_STOP);
    end

    // Target time registers, locked while a target is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsec_q <= '0;
            tsub_q <= '0;
        end else begin
            if (sel_tsec && !busy_q)            tsec_q <= wr_data_i[SEC_W-1:0];
            if (sel_tsub && !busy_q && tsub_ok) tsub_q <= wr_data_i[SUB_W-1:0];
        end
    end

    // Interval and width registers, refusing zero and in-flight changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q <= '0;
            wid_q  <= '0;
        end else begin
            if (sel_intv && cnt_ok) intv_q <= wr_data_i[CNT_W-1:0];
            if (sel_wid  && cnt_ok) wid_q  <= wr_data_i[CNT_W-1:0];
        end
    end

    // Busy flag: set by an accepted target write, cleared once the target is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                          busy_q <= 1'b0;
        else if (busy_q && reached_i)        busy_q <= 1'b0;
        else if (sel_tsub && tsub_ok)        busy_q <= 1'b1;
    end

    assign tsec_o = tsec_q;
    assign tsub_o = tsub_q;
    assign intv_o = intv_q;
    assign wid_o  = wid_q;
    assign busy_o = busy_q;

    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(A_TSUB) && !busy_q && !dec_i) |=> busy_q);
    // R3
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && reached_i) |=> !busy_q);
    // R4
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_en_i && wr_addr_i == ADDR_W'(A_TSEC)) |=> $stable(tsec_q));
    // R5
    zero_intv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(A_INTV) && wr_data_i[CNT_W-1:0] == '0) |=> $stable(intv_q));
    // R6
    dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(A_TSUB) && dec_i && wr_data_i[SUB_W-1:0] > SUB_LIMIT)
        |=> $stable(tsub_q));
endmodule

// File: rtl/fpps_train.sv
// Train controller: arms on start, fires at the target, counts ticks for
// width and interval, and honours stop at the end of the current pulse.
// Assumes interval and width do not change while armed or running.
module fpps_train
    import fpps_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req_i,
    input  logic             stop_req_i,
    input  logic             reached_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] intv_i,
    input  logic [CNT_W-1:0] wid_i,
    output logic             pps_o,
    output logic             idle_o
);
    run_state_e       state_q, state_n;
    logic [CNT_W-1:0] ph_q, ph_n;
    logic             stop_pend_q, stop_pend_n, stop_eff;

    // Next-state logic for the run state, phase counter and pending stop.
    always_comb begin
        state_n     = state_q;
        ph_n        = ph_q;
        stop_pend_n = 1'b0;
        stop_eff    = stop_pend_q || stop_req_i;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req_i && (wid_i < intv_i)) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (stop_req_i) begin
                    state_n = ST_IDLE;
                end else if (reached_i) begin
                    state_n = ST_RUN;
                    ph_n    = '0;
                end
            end
            ST_RUN: begin
                stop_pend_n = stop_eff;
                if (stop_eff && (ph_q > wid_i)) begin
                    state_n     = ST_IDLE;
                    ph_n        = '0;
                    stop_pend_n = 1'b0;
                end else if (tick_i) begin
                    if (stop_eff && (ph_q == wid_i)) begin
                        state_n     = ST_IDLE;
                        ph_n        = '0;
                        stop_pend_n = 1'b0;
                    end else if (ph_q >= intv_i) begin
                        ph_n = '0;
                    end else begin
                        ph_n = ph_q + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ph_q        <= '0;
            stop_pend_q <= 1'b0;
        end else begin
            state_q     <= state_n;
            ph_q        <= ph_n;
            stop_pend_q <= stop_pend_n;
        end
    end

    // Output: high during the first width+1 ticks of each period.
    always_comb begin
        pps_o  = (state_q == ST_RUN) && (ph_q <= wid_i);
        idle_o = (state_q == ST_IDLE);
    end

    // R8
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && reached_i && !stop_req_i) |=> pps_o);
    // R9
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_o && !tick_i) |=> pps_o);
    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !pps_o);
    // R7
    start_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_req_i && wid_i >= intv_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/fpps_gen.sv
// Top level of the flexible pulse-per-second generator.
// Assumes the time base supplies seconds, sub-seconds and a one-cycle increment tick.
module fpps_gen #(
    parameter int SEC_W       = 32,
    parameter int SUB_W       = 31,
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int SUB_DEC_MAX = 999_999_999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  sys_sec_i,
    input  logic [SUB_W-1:0]  sys_sub_i,
    input  logic              inc_tick_i,
    input  logic              dec_rollover_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              pps_o,
    output logic              trgt_busy_o
);
    logic [SEC_W-1:0] tsec;
    logic [SUB_W-1:0] tsub;
    logic [CNT_W-1:0] intv, wid;
    logic             reached, start_req, stop_req, train_idle;

    fpps_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmp (
        .sec_i    (sys_sec_i),
        .sub_i    (sys_sub_i),
        .tsec_i   (tsec),
        .tsub_i   (tsub),
        .reached_o(reached)
    );

    fpps_regs #(
        .SEC_W(SEC_W), .SUB_W(SUB_W), .CNT_W(CNT_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_DEC_MAX(SUB_DEC_MAX)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .dec_i       (dec_rollover_i),
        .train_idle_i(train_idle),
        .reached_i   (reached),
        .tsec_o      (tsec),
        .tsub_o      (tsub),
        .intv_o      (intv),
        .wid_o       (wid),
        .busy_o      (trgt_busy_o),
        .start_req_o (start_req),
        .stop_req_o  (stop_req)
    );

    fpps_train #(.CNT_W(CNT_W)) u_train (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req_i(start_req),
        .stop_req_i (stop_req),
        .reached_i  (reached),
        .tick_i     (inc_tick_i),
        .intv_i     (intv),
        .wid_i      (wid),
        .pps_o      (pps_o),
        .idle_o     (train_idle)
    );
endmodule

// File: tb/tb_fpps_gen.sv
module tb_fpps_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sys_sec = '0;
    logic [30:0] sys_sub = '0;
    logic        tick = 1'b0;
    logic        dec = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pps, busy;

    int    compared = 0;
    int    mismatched = 0;
    int    cyc = 0;
    int    tick_div = 1;
    bit    checking = 0;
    string tag = "R1";

    // behavioural reference state
    longint m_tsec, m_tsub, m_intv, m_wid, m_ph;
    int     m_st;      // 0 idle, 1 armed, 2 running
    bit     m_busy, m_sp;

    fpps_gen dut (
        .clk(clk), .rst_n(rst_n), .sys_sec_i(sys_sec), .sys_sub_i(sys_sub),
        .inc_tick_i(tick), .dec_rollover_i(dec), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pps_o(pps), .trgt_busy_o(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // time base: 100 sub-second units per tick, 10 ticks per second
    always @(negedge clk) begin
        cyc++;
        if (tick) begin
            if (sys_sub + 100 >= 1000) begin
                sys_sub = '0;
                sys_sec = sys_sec + 1;
            end else sys_sub = sys_sub + 31'd100;
        end
        tick = ((cyc % tick_div) == 0);
    end

    // reference model, updated at each rising edge from pre-edge inputs
    always @(posedge clk) begin
        bit     reached, stop_eff, w_ctrl;
        int     n_st;
        longint n_ph;
        bit     n_sp, n_busy;
        if (!rst_n) begin
            m_tsec = 0; m_tsub = 0; m_intv = 0; m_wid = 0; m_ph = 0;
            m_st = 0; m_busy = 0; m_sp = 0;
        end else begin
            reached = (longint'(sys_sec) > m_tsec) ||
                      (longint'(sys_sec) == m_tsec && longint'(sys_sub) >= m_tsub);
            w_ctrl = wr_en && wr_addr == 3'd0;
            n_st = m_st; n_ph = m_ph; n_sp = 0; n_busy = m_busy;
            if (m_st == 0) begin
                if (w_ctrl && wr_data[3:0] == 4'h2 && wr_data[9:8] == 2'h2 && m_wid < m_intv) n_st = 1;
            end else if (m_st == 1) begin
                if (w_ctrl && wr_data[3:0] == 4'h5) n_st = 0;
                else if (reached) begin n_st = 2; n_ph = 0; end
            end else begin
                stop_eff = m_sp || (w_ctrl && wr_data[3:0] == 4'h5);
                n_sp = stop_eff;
                if (stop_eff && m_ph > m_wid) begin n_st = 0; n_ph = 0; n_sp = 0; end
                else if (tick) begin
                    if (stop_eff && m_ph == m_wid) begin n_st = 0; n_ph = 0; n_sp = 0; end
                    else if (m_ph >= m_intv) n_ph = 0;
                    else n_ph = m_ph + 1;
                end
            end
            if (m_busy && reached) n_busy = 0;
            else if (wr_en && wr_addr == 3'd2 && !(dec && wr_data[30:0] > 999_999_999)) n_busy = 1;
            if (wr_en && !m_busy) begin
                case (wr_addr)
                    3'd1: m_tsec = wr_data;
                    3'd2: if (!(dec && wr_data[30:0] > 999_999_999)) m_tsub = wr_data[30:0];
                    3'd3: if (m_st == 0 && wr_data != 0) m_intv = wr_data;
                    3'd4: if (m_st == 0 && wr_data != 0) m_wid = wr_data;
                    default: ;
                endcase
            end
            m_st = n_st; m_ph = n_ph; m_sp = n_sp; m_busy = n_busy;
        end
    end

    // compare both outputs on every clock, away from the active edge
    always @(negedge clk) begin
        bit e_pps;
        if (checking) begin
            e_pps = (m_st == 2) && (m_ph <= m_wid);
            compared++;
            if (pps !== e_pps || busy !== m_busy) begin
                mismatched++;
                $display("FAIL %s cycle %0d: pps=%0b busy=%0b expected pps=%0b busy=%0b",
                         tag, cyc, pps, busy, e_pps, m_busy);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected end before 150000 cycles");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compared++;
        if (pps !== 1'b0 || busy !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset: pps=%0b busy=%0b expected 0 0", pps, busy);
        end
        checking = 1;
        idle(3);

        tag = "R2 R5 zero write";
        wr(3'd3, 32'd5); wr(3'd4, 32'd1); wr(3'd3, 32'd0); wr(3'd4, 32'd0);
        tag = "R7 wrong mode";
        wr(3'd0, 32'h0000_0102); idle(4);
        tag = "R11 other command";
        wr(3'd0, 32'h0000_0207); idle(4);

        tag = "R3 R4 busy lock";
        wr(3'd1, 32'd4); wr(3'd2, 32'd500); wr(3'd1, 32'd0); wr(3'd3, 32'd9);
        tag = "R8 start";
        wr(3'd0, 32'h0000_0202); idle(80);
        tag = "R9 periodic";
        idle(40);
        tag = "R5 locked while running";
        wr(3'd3, 32'd2); idle(15);
        tag = "R11 command while running";
        wr(3'd0, 32'h0000_0203); idle(10);
        tag = "R10 stop running";
        wr(3'd0, 32'h0000_0005); idle(20);

        tag = "R10 stop armed";
        wr(3'd1, sys_sec + 32'd30); wr(3'd2, 32'd0); wr(3'd0, 32'h0000_0202);
        idle(5); wr(3'd0, 32'h0000_0005); idle(330);

        tag = "R6 decimal range";
        dec = 1'b1; wr(3'd2, 32'd1_000_000_000); idle(4);
        tag = "R6 binary rollover";
        dec = 1'b0; wr(3'd2, 32'd1_000_000_000); idle(4);
        dec = 1'b1;

        tag = "R7 width not below interval";
        wr(3'd3, 32'd4); wr(3'd4, 32'd4); wr(3'd1, 32'd0); wr(3'd2, 32'd0);
        idle(3); wr(3'd0, 32'h0000_0202); idle(10);

        tag = "R9 slow tick";
        tick_div = 3;
        wr(3'd3, 32'd6); wr(3'd4, 32'd2); wr(3'd1, sys_sec + 32'd2); wr(3'd2, 32'd300);
        wr(3'd0, 32'h0000_0202); idle(200);
        tag = "R10 stop in high phase";
        while (pps !== 1'b1) @(negedge clk);
        wr(3'd0, 32'h0000_0005); idle(60);

        tag = "R9 minimum interval";
        tick_div = 1;
        wr(3'd4, 32'd1); wr(3'd3, 32'd2); wr(3'd1, sys_sec); wr(3'd2, 32'd0);
        idle(3); wr(3'd0, 32'h0000_0202); idle(40);
        tag = "R10 stop in low phase";
        while (pps !== 1'b0) @(negedge clk);
        wr(3'd0, 32'h0000_0005); idle(20);

        checking = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule